// File: doc/BRIEF.md
# Watchdog Event Reset Sequencer

This block turns an expiry event from a timer or watchdog into a reset action chosen by software. It holds one 32-bit control word, written and read through a plain register port. The word contains a lock bit, a three-bit action mode, a three-bit delay code, a sticky event flag and a write-one-to-clear strobe for that flag.

In the interrupt-then-reset mode, a rising edge on the event input raises a non-maskable interrupt request for one core cycle. After that the block counts ticks of a divide-by-six enable, and when the programmed number of ticks has elapsed it drives a local reset pulse of fixed length. In every other mode the event is only recorded in the sticky flag.

Top module: `wdog_rst_seq`

## Requirements
- R1: After reset the register reads 0x0000_0080: lock 0, mode 000, flag 0 and delay code 100b (bits 7:5). Both `nmi_req` and `lrst_req` are low.
- R2: Bits 31:10 and bit 8 always read 0. Bit 9 (the clear strobe) also always reads 0.
- R3: When the lock (bit 0) is 0, a write loads the lock from bit 0, the mode from bits 3:1 and the delay code from bits 7:5. The lock value before the write decides whether the fields are taken.
- R4: When the lock is 1, a write leaves the mode and delay fields unchanged, but it still updates the lock bit.
- R5: The event flag (bit 4) is set one cycle after `event_in` is seen rising. It stays set, and writing bit 4 has no effect on it.
- R6: Writing 1 to bit 9 clears the flag and writing 0 there has no effect. If a clear and a new rising edge arrive in the same cycle, the flag ends up set.
- R7: When the mode is 100b and the sequencer is idle, a rising edge on `event_in` drives `nmi_req` high for exactly one cycle, starting the cycle after the edge is sampled.
- R8: `lrst_req` rises exactly 6·256·2^n core cycles after `nmi_req` rises, where n is the delay code latched at the event.
- R9: `lrst_req` stays high for exactly 8 core cycles and is never high in the same cycle as `nmi_req`.
- R10: Rising edges that arrive before the local reset pulse has ended start no second interrupt and no second reset. They still set the flag.
- R11: With any mode other than 100b, an event drives neither `nmi_req` nor `lrst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| event_in | input | 1 | Timer or watchdog expiry level; its rising edge is the event |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| lrst_req | output | 1 | Local reset pulse |

## Verification
The assertions check a set of properties on every cycle. The reserved bits read zero. The interrupt request is a single cycle and never overlaps the reset. The mode and delay fields hold across a write made while the lock is set. A rising edge on the event input sets the flag. Outside mode 100b, an event from idle raises no interrupt. The exact delay from interrupt to reset for each delay code, the reset pulse length, the handling of a clear and an event in the same cycle, and the way repeat events are ignored during a sequence can only be shown by the bench's timed scenarios.

// File: rtl/wdog_rst_seq.sv
module wdog_rst_seq #(
  parameter int DIV        = 6,
  parameter int BASE_LOG2  = 8,
  parameter int PULSE_LEN  = 8,
  parameter int DLY_W      = 3,
  parameter logic [2:0] SEQ_MODE = 3'b100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        event_in,
  output logic        nmi_req,
  output logic        lrst_req
);
  localparam int CNT_W = BASE_LOG2 + (1 << DLY_W);
  localparam int DIV_W = $clog2(DIV);
  localparam int PL_W  = $clog2(PULSE_LEN);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PULSE} st_t;

  logic             lock;
  logic [2:0]       omode;
  logic [DLY_W-1:0] dly;
  logic             evtstat;
  logic             ev_q;
  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div;
  logic [PL_W-1:0]  plen;

  wire ev_rise = event_in & ~ev_q;
  wire clr     = reg_we & reg_wdata[9];
  wire tick    = (div == DIV_W'(DIV - 1));
  wire start   = (st == S_IDLE) && ev_rise && (omode == SEQ_MODE);

  assign reg_rdata = {22'd0, 1'b0, 1'b0, dly, evtstat, omode, lock};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock    <= 1'b0;
      omode   <= 3'b000;
      dly     <= DLY_W'(4);
      evtstat <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      ev_q <= event_in;
      if (ev_rise)  evtstat <= 1'b1;
      else if (clr) evtstat <= 1'b0;
      if (reg_we) begin
        lock <= reg_wdata[0];
        if (!lock) begin
          omode <= reg_wdata[3:1];
          dly   <= reg_wdata[5 +: DLY_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      div      <= '0;
      plen     <= '0;
      nmi_req  <= 1'b0;
      lrst_req <= 1'b0;
    end else begin
      nmi_req <= start;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_WAIT;
          div <= '0;
          cnt <= CNT_W'(1) << (BASE_LOG2 + int'(dly));
        end
        S_WAIT: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
              st       <= S_PULSE;
              plen     <= '0;
              lrst_req <= 1'b1;
            end
          end
        end
        S_PULSE: begin
          plen <= plen + 1'b1;
          if (plen == PL_W'(PULSE_LEN - 1)) begin
            lrst_req <= 1'b0;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdog_rst_seq_chk.sv
module wdog_rst_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [31:0] reg_rdata,
  input logic        event_in,
  input logic        nmi_req,
  input logic        lrst_req,
  input logic        idle
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:8] == 24'd0); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_rdata[0]) |=> (reg_rdata[7:5] == $past(reg_rdata[7:5]) &&
                                  reg_rdata[3:1] == $past(reg_rdata[3:1]))); // R4
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(event_in) |=> reg_rdata[4]); // R5
  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req && lrst_req)); // R9
  AST_OTHER_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(event_in) && idle && reg_rdata[3:1] != 3'b100) |=> !nmi_req); // R11
endmodule

bind wdog_rst_seq wdog_rst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .event_in(event_in), .nmi_req(nmi_req), .lrst_req(lrst_req),
  .idle(st == S_IDLE)
);

// File: tb/test_wdog_rst_seq.sv
module test_wdog_rst_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        event_in = 0;
  logic        nmi_req, lrst_req;

  int errors = 0, checks = 0;
  int ncyc = 0, nmi_cnt = 0, lrst_cnt = 0, nmi_first = -1, lrst_first = -1;

  always #4 clk = ~clk;

  wdog_rst_seq i_wdog_rst_seq (.*);

  always @(negedge clk) begin
    ncyc++;
    if (nmi_req)  begin nmi_cnt++;  if (nmi_first < 0)  nmi_first = ncyc; end
    if (lrst_req) begin lrst_cnt++; if (lrst_first < 0) lrst_first = ncyc; end
  end

  localparam int NV = 6;
  localparam logic        V_WE [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_WD [NV] = '{32'h0, 32'hFFFF_FFFE, 32'h29, 32'hE7, 32'h0, 32'h4};
  localparam logic [31:0] V_EX [NV] = '{32'h80, 32'hEE, 32'h29, 32'h29, 32'h28, 32'h4};
  localparam int          V_RQ [NV] = '{1, 2, 3, 4, 4, 3};
  // rows: R1 reset value, R2+R3 all-ones write, R3 lock+fields, R4 locked write, R4 unlock, R3 plain write

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); #1; reg_we = 1; reg_wdata = d;
    @(negedge clk); #1; reg_we = 0;
  endtask

  task automatic clr_mon();
    nmi_cnt = 0; lrst_cnt = 0; nmi_first = -1; lrst_first = -1;
  endtask

  task automatic run_seq(input int code);
    int ev_n;
    int d;
    wr(32'h8 | (code << 5));
    clr_mon();
    @(negedge clk); #1; event_in = 1; ev_n = ncyc;
    @(negedge clk); #1; event_in = 0;
    repeat (50) @(negedge clk);
    #1 event_in = 1;                      // R10 repeat event mid-sequence
    @(negedge clk); #1; event_in = 0;
    d = 6 * (256 << code);
    repeat (d + 100) @(negedge clk);
    #1;
    chk("R7 nmi start", nmi_first, ev_n + 1);
    chk("R7 R10 nmi count", nmi_cnt, 1);
    chk("R8 delay", lrst_first - nmi_first, d);
    chk("R9 R10 lrst len", lrst_cnt, 8);
    chk("R10 flag", reg_rdata[4], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk("R1 nmi", nmi_req, 0);
    chk("R1 lrst", lrst_req, 0);

    for (int i = 0; i < NV; i++) begin
      if (V_WE[i]) wr(V_WD[i]); else begin @(negedge clk); #1; end
      chk($sformatf("R%0d vec%0d", V_RQ[i], i), reg_rdata, V_EX[i]);
    end

    wr(32'h10);
    chk("R5 bit4 write", reg_rdata, 32'h0);
    clr_mon();
    @(negedge clk); #1; event_in = 1;
    repeat (2) @(negedge clk); #1; event_in = 0;
    chk("R5 flag set", reg_rdata[4], 1'b1);
    repeat (20) @(negedge clk); #1;
    chk("R5 sticky", reg_rdata[4], 1'b1);
    chk("R11 mode0 outputs", nmi_cnt + lrst_cnt, 0);
    wr(32'h0);
    chk("R6 write0 keeps", reg_rdata[4], 1'b1);
    wr(32'h200);
    chk("R6 clear", reg_rdata, 32'h0);
    chk("R2 bit9 reads0", reg_rdata[9], 1'b0);
    @(negedge clk); #1; event_in = 1; reg_we = 1; reg_wdata = 32'h200;
    @(negedge clk); #1; reg_we = 0; event_in = 0;
    chk("R6 event wins", reg_rdata[4], 1'b1);

    wr(32'h20A);                           // mode 101, clear flag
    clr_mon();
    @(negedge clk); #1; event_in = 1;
    @(negedge clk); #1; event_in = 0;
    repeat (1700) @(negedge clk); #1;
    chk("R11 mode5 outputs", nmi_cnt + lrst_cnt, 0);

    run_seq(0);
    run_seq(1);

    @(negedge clk); #1 rst_n = 0;
    @(negedge clk); #1 rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset again", reg_rdata, 32'h80);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule